// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for many processes at the same time. Every entry carries an address-space tag in addition to its page number. A context switch therefore only reloads a small tag register and does not discard cached translations. A lookup hits when a valid entry holds the requested virtual page and that entry's tag equals the tag currently loaded.

Translations enter through a refill port, which either software or a page walker drives. Each refill is stamped with the current tag. A refill normally goes into the slot named by a round-robin pointer. If a valid entry already holds the same page under the current tag, the refill rewrites that entry in place, so no duplicate is created. When the operating system runs out of tags and has to hand them out again, it issues a single flush command that invalidates the whole buffer in one cycle.

The lookup compares against all entries in parallel. The hit, miss and physical page result is registered and appears one cycle after the request.

Top module: `asid_tlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, the current tag `cur_asid` is 0, the refill pointer is at slot 0, and `res_valid`, `res_hit`, `res_miss` and `res_ppn` are all 0.
- R2: The lookup result is registered.
  - `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high.
  - In that cycle exactly one of `res_hit` and `res_miss` is high.
  - Both are low when `res_valid` is low.
- R3: A lookup hits only if a valid entry stores both the requested page and the tag held in `cur_asid`. On a hit, `res_ppn` returns that entry's physical page. On a miss, `res_ppn` is 0.
- R4: A refill stores the value `cur_asid` holds in the refill cycle. A tag written through `asid_we` in the same cycle takes effect on the next cycle, for both lookups and refills.
- R5: Changing `cur_asid` keeps the entries of other tags. Switching back to an earlier tag makes its entries hit again.
- R6: A refill that creates a new entry writes the slot under the round-robin pointer. The pointer then advances by one, wrapping from 63 to 0. With 64 entries, the 65th distinct refill after a flush replaces the first.
- R7: A refill whose page and current tag match an existing valid entry rewrites that entry's physical page in place. The pointer does not move, and at most one entry ever hits.
- R8: When `flush` is high, every entry becomes invalid on the next cycle and the pointer returns to 0. A refill in the same cycle as a flush is dropped.
- R9: A lookup issued in the same cycle as a refill or a flush sees the buffer contents from before that write.
- R10: A lookup that misses leaves the contents unchanged. Valid bits only change on a refill or a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| asid_we | input | 1 | Load `asid_wdata` into the current tag register |
| asid_wdata | input | 6 | New address-space tag |
| cur_asid | output | 6 | Current address-space tag |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to translate |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page of the refill |
| fill_ppn | input | 20 | Physical page of the refill |
| flush | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Lookup result present (one cycle after request) |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup miss |
| res_ppn | output | 20 | Translated physical page, 0 on miss |

## Verification
The one-hot hit check assumes the refill port is the only way entries are written. That makes the no-duplicate rule on refill the sole reason two entries cannot match one key, and the stimulus writes nothing else. The stability and flush properties assume `fill_valid` and `flush` are the only write strobes. The bench holds every strobe low during reset and for one cycle at a time otherwise, so each property sees well-defined single-cycle requests. The stimulus deliberately stacks a refill, a tag change and a lookup in the same cycle, and a flush with a refill and a lookup. This exercises the ordering rules without ever driving an undefined value.

// File: rtl/tlb_pkg.sv
// Package: shared types of the tagged translation buffer.
// Assumes: nothing; pure type definitions.
package tlb_pkg;

    // What a refill request does to the entry array in a given cycle
    typedef enum logic [1:0] {
        FILL_DROP   = 2'd0,   // no refill, or refill overridden by flush
        FILL_UPDATE = 2'd1,   // same page and tag already cached: rewrite in place
        FILL_ALLOC  = 2'd2    // new translation: write the victim slot
    } fill_act_e;

endpackage

// File: rtl/tlb_store.sv
// Module: tlb_store
// Holds the entry array: valid bits, virtual page, tag and physical page.
// Assumes: at most one write per cycle; flush has priority over a write
// (the caller already suppresses wr_en during flush, flush wins regardless).
module tlb_store #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 6,
    parameter int PPN_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [ASID_W-1:0]           wr_asid,
    input  logic [PPN_W-1:0]            wr_ppn,
    output logic [N-1:0]                valid_o,
    output logic [N-1:0][VPN_W-1:0]     vpn_o,
    output logic [N-1:0][ASID_W-1:0]    asid_o,
    output logic [N-1:0][PPN_W-1:0]     ppn_o
);

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Valid bit: cleared by reset or flush, set when this slot is written
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                valid_o[g] <= 1'b0;
            else if (sel)
                valid_o[g] <= 1'b1;
        end

        // Payload: captured on a write, no reset needed because valid guards it
        always_ff @(posedge clk) begin
            if (sel && !flush) begin
                vpn_o[g]  <= wr_vpn;
                asid_o[g] <= wr_asid;
                ppn_o[g]  <= wr_ppn;
            end
        end
    end

endmodule

// File: rtl/tlb_match.sv
// Module: tlb_match
// Parallel tag compare: one hit bit per entry for a (page, tag) key.
// Assumes: only entries with the valid bit set may hit.
module tlb_match #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 6
) (
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0][VPN_W-1:0]  vpn_i,
    input  logic [N-1:0][ASID_W-1:0] asid_i,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Entry g matches when valid and both tag fields agree
        assign hit_o[g] = valid_i[g] && (vpn_i[g] == key_vpn) && (asid_i[g] == key_asid);
    end

endmodule

// File: rtl/tlb_encode.sv
// Module: tlb_encode
// Turns a hit vector into an any-hit flag and a binary slot index.
// Assumes: the vector is one-hot or zero (no duplicate entries).
module tlb_encode #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // OR-reduce the indices of set bits; exact for a one-hot input
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++)
            if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/tlb_victim.sv
// Module: tlb_victim
// Round-robin replacement pointer over N slots.
// Assumes: clear (flush) wins over advance in the same cycle.
module tlb_victim #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr_o
);

    // Step the pointer after each allocation, wrapping at the last slot
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ptr_o <= '0;
        else if (advance)
            ptr_o <= (ptr_o == IDX_W'(N - 1)) ? '0 : ptr_o + 1'b1;
    end

endmodule

// File: rtl/asid_tlb.sv
// Module: asid_tlb (top)
// Fully associative translation buffer whose entries carry an address-space
// tag. Lookup compares in parallel and registers hit/miss/ppn one cycle later.
// Refills are stamped with the current tag and either rewrite an identical
// cached translation or allocate the round-robin victim. Flush empties all.
// Assumes: a lookup in the same cycle as a write sees the old contents; a tag
// write takes effect from the following cycle.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 6,
    parameter int PPN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    output logic [ASID_W-1:0] cur_asid,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              flush,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [PPN_W-1:0]  res_ppn
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]              valid_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_arr;
    logic [ENTRIES-1:0][ASID_W-1:0]  asid_arr;
    logic [ENTRIES-1:0][PPN_W-1:0]   ppn_arr;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] fill_hit_vec;
    logic               lk_any;
    logic               fill_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   victim_ptr;

    fill_act_e          fill_act;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;

    // Current address-space tag, reloaded on context switch
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_asid <= '0;
        else if (asid_we)
            cur_asid <= asid_wdata;
    end

    tlb_store #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_vpn  (fill_vpn),
        .wr_asid (cur_asid),
        .wr_ppn  (fill_ppn),
        .valid_o (valid_vec),
        .vpn_o   (vpn_arr),
        .asid_o  (asid_arr),
        .ppn_o   (ppn_arr)
    );

    tlb_match #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
    ) u_lk_match (
        .valid_i  (valid_vec),
        .vpn_i    (vpn_arr),
        .asid_i   (asid_arr),
        .key_vpn  (lk_vpn),
        .key_asid (cur_asid),
        .hit_o    (lk_hit_vec)
    );

    tlb_match #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
    ) u_fill_match (
        .valid_i  (valid_vec),
        .vpn_i    (vpn_arr),
        .asid_i   (asid_arr),
        .key_vpn  (fill_vpn),
        .key_asid (cur_asid),
        .hit_o    (fill_hit_vec)
    );

    tlb_encode #(.N(ENTRIES)) u_lk_enc (
        .vec_i (lk_hit_vec),
        .any_o (lk_any),
        .idx_o (lk_idx)
    );

    tlb_encode #(.N(ENTRIES)) u_fill_enc (
        .vec_i (fill_hit_vec),
        .any_o (fill_any),
        .idx_o (fill_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .advance (fill_act == FILL_ALLOC),
        .ptr_o   (victim_ptr)
    );

    // Classify the refill request for this cycle
    always_comb begin
        if (!fill_valid || flush)
            fill_act = FILL_DROP;
        else if (fill_any)
            fill_act = FILL_UPDATE;
        else
            fill_act = FILL_ALLOC;
    end

    // Steer the write to the matching slot or to the victim slot
    always_comb begin
        wr_en  = (fill_act != FILL_DROP);
        wr_idx = (fill_act == FILL_UPDATE) ? fill_idx : victim_ptr;
    end

    // Register the lookup result one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_ppn   <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && lk_any;
            res_miss  <= lk_valid && !lk_any;
            res_ppn   <= (lk_valid && lk_any) ? ppn_arr[lk_idx] : '0;
        end
    end

endmodule

// File: rtl/tlb_checker.sv
// Module: tlb_checker
// Temporal checks on the translation buffer, attached to asid_tlb by bind.
// Assumes: refill and flush are the only writers of the entry array.
module tlb_checker #(
    parameter int N     = 64,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             fill_valid,
    input logic             flush,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic [PPN_W-1:0] res_ppn,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     lk_hit_vec
);

    a_r2_result_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    a_r2_no_result_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    a_r2_idle_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_miss));

    a_r3_miss_ppn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_ppn == '0));

    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    a_r6_fill_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> (valid_vec != '0));

    a_r10_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_valid && !flush) |=> $stable(valid_vec));

endmodule

bind asid_tlb tlb_checker #(.N(ENTRIES), .PPN_W(PPN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .fill_valid (fill_valid),
    .flush      (flush),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_ppn    (res_ppn),
    .valid_vec  (valid_vec),
    .lk_hit_vec (lk_hit_vec)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the tagged buffer, compared every clock.
module asid_tlb_test;

    localparam int NE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        asid_we = 1'b0;
    logic [5:0]  asid_wdata = '0;
    logic [5:0]  cur_asid;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        flush = 1'b0;
    logic        res_valid, res_hit, res_miss;
    logic [19:0] res_ppn;

    int errors = 0;
    int checks = 0;

    // Reference state
    bit          m_v    [NE];
    int          m_vpn  [NE];
    int          m_asid [NE];
    int          m_ppn  [NE];
    int          m_ptr  = 0;
    int          m_cur  = 0;
    bit          e_valid = 0, e_hit = 0, e_miss = 0;
    int          e_ppn  = 0;

    always #2.5 clk = ~clk;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n), .asid_we(asid_we), .asid_wdata(asid_wdata),
        .cur_asid(cur_asid), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .flush(flush), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_ppn(res_ppn)
    );

    // Advance the model by one clock edge using the inputs present at the edge
    task automatic model_edge();
        int hit_at = -1;
        int fill_at = -1;
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_ptr = 0; m_cur = 0;
            e_valid = 0; e_hit = 0; e_miss = 0; e_ppn = 0;
            return;
        end
        foreach (m_v[i])
            if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_asid[i] == m_cur) hit_at = i;
        e_valid = lk_valid;
        e_hit   = lk_valid && hit_at >= 0;
        e_miss  = lk_valid && hit_at < 0;
        e_ppn   = e_hit ? m_ppn[hit_at] : 0;
        if (flush) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_ptr = 0;
        end else if (fill_valid) begin
            foreach (m_v[i])
                if (m_v[i] && m_vpn[i] == int'(fill_vpn) && m_asid[i] == m_cur) fill_at = i;
            if (fill_at < 0) begin
                fill_at = m_ptr;
                m_ptr = (m_ptr + 1) % NE;
            end
            m_v[fill_at] = 1; m_vpn[fill_at] = int'(fill_vpn);
            m_asid[fill_at] = m_cur; m_ppn[fill_at] = int'(fill_ppn);
        end
        if (asid_we) m_cur = int'(asid_wdata);
    endtask

    // One clock: edge, model step, then compare outputs away from the edge
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        checks++;
        if (res_valid !== e_valid || res_hit !== e_hit || res_miss !== e_miss ||
            res_ppn !== 20'(e_ppn) || cur_asid !== 6'(m_cur)) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b m=%0b ppn=%h asid=%0d, expected v=%0b h=%0b m=%0b ppn=%h asid=%0d",
                     tag, res_valid, res_hit, res_miss, res_ppn, cur_asid,
                     e_valid, e_hit, e_miss, 20'(e_ppn), m_cur);
        end
        asid_we = 0; lk_valid = 0; fill_valid = 0; flush = 0;
    endtask

    // Directed check against a fixed expectation from the requirements
    task automatic expect_res(input bit hit, input logic [19:0] ppn, input string tag);
        checks++;
        if (res_valid !== 1'b1 || res_hit !== hit || res_ppn !== (hit ? ppn : 20'h0)) begin
            errors++;
            $display("FAIL %s: got hit=%0b ppn=%h, expected hit=%0b ppn=%h",
                     tag, res_hit, res_ppn, hit, hit ? ppn : 20'h0);
        end
    endtask

    task automatic lookup(input logic [19:0] v, input string tag);
        lk_valid = 1; lk_vpn = v; tick(tag);
    endtask

    task automatic refill(input logic [19:0] v, input logic [19:0] p, input string tag);
        fill_valid = 1; fill_vpn = v; fill_ppn = p; tick(tag);
    endtask

    task automatic set_asid(input logic [5:0] a, input string tag);
        asid_we = 1; asid_wdata = a; tick(tag);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        #1;
        repeat (3) tick("R1");
        rst_n = 1;
        tick("R1");
        lookup(20'h00000, "R1");
        expect_res(0, 20'h0, "R1");

        // R3: hits need page and tag; misses give zero ppn
        set_asid(6'd5, "R4");
        refill(20'h00010, 20'hA0010, "R3");
        refill(20'h00020, 20'hA0020, "R3");
        lookup(20'h00010, "R3");
        expect_res(1, 20'hA0010, "R3");
        lookup(20'h00030, "R10");
        expect_res(0, 20'h0, "R10");
        lookup(20'h00020, "R10");
        expect_res(1, 20'hA0020, "R10");

        // R5: other tag misses, own entry retained across switches
        set_asid(6'd9, "R5");
        lookup(20'h00010, "R5");
        expect_res(0, 20'h0, "R5");
        refill(20'h00010, 20'hB0010, "R5");
        lookup(20'h00010, "R5");
        expect_res(1, 20'hB0010, "R5");
        set_asid(6'd5, "R5");
        lookup(20'h00010, "R5");
        expect_res(1, 20'hA0010, "R5");

        // R4: refill and tag write in one cycle: refill stamped with old tag
        fill_valid = 1; fill_vpn = 20'h00040; fill_ppn = 20'hC0040;
        asid_we = 1; asid_wdata = 6'd12;
        lk_valid = 1; lk_vpn = 20'h00010;
        tick("R4");
        expect_res(1, 20'hA0010, "R4");
        lookup(20'h00040, "R4");
        expect_res(0, 20'h0, "R4");
        set_asid(6'd5, "R4");
        lookup(20'h00040, "R4");
        expect_res(1, 20'hC0040, "R4");

        // R7: duplicate refill rewrites in place
        refill(20'h00020, 20'hD0020, "R7");
        lookup(20'h00020, "R7");
        expect_res(1, 20'hD0020, "R7");

        // R9: lookup with same-cycle refill sees old contents
        lk_valid = 1; lk_vpn = 20'h00050;
        fill_valid = 1; fill_vpn = 20'h00050; fill_ppn = 20'hE0050;
        tick("R9");
        expect_res(0, 20'h0, "R9");
        lookup(20'h00050, "R9");
        expect_res(1, 20'hE0050, "R9");

        // R8/R9: flush with lookup and refill in the same cycle
        flush = 1; lk_valid = 1; lk_vpn = 20'h00050;
        fill_valid = 1; fill_vpn = 20'h00060; fill_ppn = 20'hF0060;
        tick("R8");
        expect_res(1, 20'hE0050, "R9");
        lookup(20'h00050, "R8");
        expect_res(0, 20'h0, "R8");
        lookup(20'h00060, "R8");
        expect_res(0, 20'h0, "R8");

        // R6: 65 distinct refills wrap the pointer onto slot 0
        for (int i = 0; i < NE + 1; i++)
            refill(20'(32'h100 + i), 20'(32'h50000 + i), "R6");
        lookup(20'h00100, "R6");
        expect_res(0, 20'h0, "R6");
        lookup(20'h00101, "R6");
        expect_res(1, 20'h50001, "R6");
        lookup(20'h00140, "R6");
        expect_res(1, 20'h50040, "R6");
        refill(20'h00200, 20'h66666, "R6");
        lookup(20'h00101, "R6");
        expect_res(0, 20'h0, "R6");
        lookup(20'h00200, "R6");
        expect_res(1, 20'h66666, "R6");

        // R1: reset in mid-run empties everything
        rst_n = 0;
        tick("R1");
        rst_n = 1;
        lookup(20'h00200, "R1");
        expect_res(0, 20'h0, "R1");
        tick("R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule